// File: doc/BRIEF.md
# SDRAM Row Activation Timing Guard

This block sits between a memory request scheduler and the command pins of a single-data-rate SDRAM with four banks. The scheduler presents one command at a time (activate a row, read, write or precharge) with a bank and an address. The block tracks, for every bank, whether a row is open. It also tracks how many cycles remain before each timing limit expires. It grants the request only when the command is legal and every limit that applies has run out. It then drives the command pins for one cycle. In all other cycles the pins carry a no-operation command.

Timing limits are parameters in picoseconds. At elaboration they are turned into clock cycles by dividing by the clock period and rounding up, with a floor of one cycle. Four limits are enforced: activate-to-access delay within a bank, activate-to-activate spacing within a bank, activate-to-activate spacing across banks, and precharge-to-activate recovery within a bank.

A request that breaks the open-row rule is not issued. The block consumes it at once, so the scheduler never stalls on it, and raises an error flag that stays set until reset.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset all banks are closed, the error flag is 0, and the pins carry no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R2: The request code is 0 activate, 1 read, 2 write, 3 precharge. A granted request appears on the pins in the cycle after acceptance, with {cs_n,ras_n,cas_n,we_n} set to activate 0011, read 0101, write 0100, precharge 0010. Bank and address are copied from the request.
- R3: A read or write to a closed bank is accepted at once (ready high) and not issued. The pins stay no-operation and the error flag is set.
- R4: An activate to a bank that already has an open row is accepted at once and not issued. The pins stay no-operation and the error flag is set.
- R5: A read or write to a bank is accepted no earlier than RCD cycles after that bank's activate was accepted.
- R6: Two activates to the same bank are accepted at least RC cycles apart.
- R7: Two activates to any banks are accepted at least RRD cycles apart.
- R8: An activate to a bank is accepted no earlier than RP cycles after that bank's precharge was accepted. A precharge closes the bank.
- R9: Each cycle count equals the limit in picoseconds divided by the clock period, rounded up, and is at least 1.
- R10: Once set, the error flag stays set until reset.
- R11: While a legal request waits on a timing limit, ready is low and the pins carry no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Request code: 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | 2 | Target bank |
| req_addr | input | 12 | Row for activate, column for read and write |
| req_ready | output | 1 | Request accepted this cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank pins |
| addr | output | 12 | Address pins |
| err | output | 1 | Sticky rule-violation flag |

## Verification
The bench builds the block with a 20 ns period and limits of 45, 130, 30 and 50 ns. These round up to 3, 7, 2 and 3 cycles, so none of the divisions is exact and rounding down would show up as an early grant. The row-cycle limit is longer than activate-plus-precharge-recovery. A quick precharge followed by a reactivate therefore waits on the row-cycle counter, not on the recovery counter. Cross-bank spacing of two cycles is short enough that a back-to-back activate to a second bank waits exactly one cycle.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } req_cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_ACT = 4'b0011;
  localparam logic [3:0] PIN_RD  = 4'b0101;
  localparam logic [3:0] PIN_WR  = 4'b0100;
  localparam logic [3:0] PIN_PRE = 4'b0010;

  // Divide a limit by the clock period, round up, floor at one cycle.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned tck_ps);
    int unsigned c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sdram_act_downcnt.sv
module sdram_act_downcnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // An expired counter stays expired until reloaded (R9 counts never wrap)
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_act_bank.sv
module sdram_act_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act_go,
  input  logic         rw_go,
  input  logic         pre_go,
  input  logic [W-1:0] rcd_ld,
  input  logic [W-1:0] rc_ld,
  input  logic [W-1:0] rp_ld,
  output logic         open_o,
  output logic         rw_ok,
  output logic         act_ok
);

  logic open_q;
  logic rcd_zero, rc_zero, rp_zero;

  always_ff @(posedge clk) begin
    if (rst)         open_q <= 1'b0;
    else if (act_go) open_q <= 1'b1;
    else if (pre_go) open_q <= 1'b0;
  end

  sdram_act_downcnt #(.W(W)) u_rcd (
    .clk(clk), .rst(rst), .load(act_go), .load_val(rcd_ld), .zero(rcd_zero));

  sdram_act_downcnt #(.W(W)) u_rc (
    .clk(clk), .rst(rst), .load(act_go), .load_val(rc_ld), .zero(rc_zero));

  sdram_act_downcnt #(.W(W)) u_rp (
    .clk(clk), .rst(rst), .load(pre_go), .load_val(rp_ld), .zero(rp_zero));

  assign open_o = open_q;
  assign rw_ok  = rcd_zero;
  assign act_ok = rc_zero & rp_zero;

  p_rw_open_r3: assert property (@(posedge clk) disable iff (rst)
    rw_go |-> open_q);

  p_act_closed_r4: assert property (@(posedge clk) disable iff (rst)
    act_go |-> !open_q);

  p_rw_after_rcd_r5: assert property (@(posedge clk) disable iff (rst)
    rw_go |-> rcd_zero);

  p_act_after_rp_r8: assert property (@(posedge clk) disable iff (rst)
    act_go |-> (rp_zero && rc_zero));

  p_pre_closes_r8: assert property (@(posedge clk) disable iff (rst)
    (pre_go && !act_go) |=> !open_q);

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sdram_act_pkg::*;
#(
  parameter int unsigned T_CK_PS  = 8000,
  parameter int unsigned T_RCD_PS = 20000,
  parameter int unsigned T_RC_PS  = 70000,
  parameter int unsigned T_RRD_PS = 15000,
  parameter int unsigned T_RP_PS  = 20000,
  parameter int          BA_W     = 2,
  parameter int          A_W      = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_cmd,
  input  logic [BA_W-1:0] req_bank,
  input  logic [A_W-1:0]  req_addr,
  output logic            req_ready,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [BA_W-1:0] ba,
  output logic [A_W-1:0]  addr,
  output logic            err
);

  localparam int unsigned RCD_CYC = ps_to_cyc(T_RCD_PS, T_CK_PS);
  localparam int unsigned RC_CYC  = ps_to_cyc(T_RC_PS,  T_CK_PS);
  localparam int unsigned RRD_CYC = ps_to_cyc(T_RRD_PS, T_CK_PS);
  localparam int unsigned RP_CYC  = ps_to_cyc(T_RP_PS,  T_CK_PS);
  localparam int unsigned MAXC    = max3(max3(RCD_CYC, RC_CYC, RRD_CYC), RP_CYC, 1);
  localparam int          CW      = $clog2(MAXC + 1);
  localparam int          NBANK   = 2 ** BA_W;

  localparam logic [CW-1:0] RCD_LD = CW'(RCD_CYC - 1);
  localparam logic [CW-1:0] RC_LD  = CW'(RC_CYC - 1);
  localparam logic [CW-1:0] RRD_LD = CW'(RRD_CYC - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(RP_CYC - 1);

  req_cmd_e           cmd;
  logic [NBANK-1:0]   bank_open, bank_rw_ok, bank_act_ok;
  logic [NBANK-1:0]   act_go, rw_go, pre_go;
  logic               rrd_zero;
  logic               is_act, is_rw, is_pre;
  logic               bad, timing_ok, grant;
  logic [3:0]         pins_q;
  logic [BA_W-1:0]    ba_q;
  logic [A_W-1:0]     addr_q;
  logic               err_q;

  assign cmd    = req_cmd_e'(req_cmd);
  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);

  // Open-row rule: access needs an open row, activate needs a closed bank
  assign bad = (is_rw && !bank_open[req_bank]) || (is_act && bank_open[req_bank]);

  always_comb begin
    timing_ok = 1'b1;
    if (is_act)     timing_ok = bank_act_ok[req_bank] && rrd_zero;
    else if (is_rw) timing_ok = bank_rw_ok[req_bank];
  end

  assign req_ready = bad || timing_ok;
  assign grant     = req_valid && !bad && timing_ok;

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      assign act_go[b] = grant && is_act && (req_bank == BA_W'(b));
      assign rw_go[b]  = grant && is_rw  && (req_bank == BA_W'(b));
      assign pre_go[b] = grant && is_pre && (req_bank == BA_W'(b));

      sdram_act_bank #(.W(CW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .act_go (act_go[b]),
        .rw_go  (rw_go[b]),
        .pre_go (pre_go[b]),
        .rcd_ld (RCD_LD),
        .rc_ld  (RC_LD),
        .rp_ld  (RP_LD),
        .open_o (bank_open[b]),
        .rw_ok  (bank_rw_ok[b]),
        .act_ok (bank_act_ok[b])
      );
    end
  endgenerate

  sdram_act_downcnt #(.W(CW)) u_rrd (
    .clk(clk), .rst(rst), .load(grant && is_act), .load_val(RRD_LD), .zero(rrd_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PIN_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (req_valid && bad) err_q <= 1'b1;
      if (grant) begin
        ba_q   <= req_bank;
        addr_q <= req_addr;
        unique case (cmd)
          CMD_ACT: pins_q <= PIN_ACT;
          CMD_RD:  pins_q <= PIN_RD;
          CMD_WR:  pins_q <= PIN_WR;
          CMD_PRE: pins_q <= PIN_PRE;
        endcase
      end else begin
        pins_q <= PIN_NOP;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign err  = err_q;

  p_idle_nop_r11: assert property (@(posedge clk) disable iff (rst)
    !grant |=> ({cs_n, ras_n, cas_n, we_n} == PIN_NOP));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_bad_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad) |=> (err && ({cs_n, ras_n, cas_n, we_n} == PIN_NOP)));

  p_act_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (grant && is_act && (RRD_CYC > 1)) |=> !rrd_zero);

  p_grant_pins_r2: assert property (@(posedge clk) disable iff (rst)
    grant |=> (!cs_n && (ba == $past(req_bank)) && (addr == $past(req_addr))));

endmodule

// File: tb/sdram_act_guard_bench.sv
module sdram_act_guard_bench;

  localparam int unsigned TCK  = 20000;
  localparam int unsigned TRCD = 45000;
  localparam int unsigned TRC  = 130000;
  localparam int unsigned TRRD = 30000;
  localparam int unsigned TRP  = 50000;

  // Expected cycle counts, worked out by hand from R9
  localparam int E_RCD = 3;   // 45/20 = 2.25 -> 3
  localparam int E_RC  = 7;   // 130/20 = 6.5 -> 7
  localparam int E_RRD = 2;   // 30/20 = 1.5 -> 2
  localparam int E_RP  = 3;   // 50/20 = 2.5 -> 3

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;

  logic clk = 0;
  logic rst;
  logic req_valid;
  logic [1:0] req_cmd, req_bank;
  logic [11:0] req_addr;
  logic req_ready, cs_n, ras_n, cas_n, we_n, err;
  logic [1:0] ba;
  logic [11:0] addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  sdram_act_guard #(
    .T_CK_PS(TCK), .T_RCD_PS(TRCD), .T_RC_PS(TRC), .T_RRD_PS(TRRD), .T_RP_PS(TRP)
  ) u_sdram_act_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_addr(req_addr), .req_ready(req_ready), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .err(err)
  );

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0; req_cmd = 0; req_bank = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Presents a request at a falling edge, counts rejected edges, returns them.
  // Checks pins stay NOP while waiting (R11). Leaves time at the negedge after acceptance.
  task automatic issue(input logic [1:0] c, input logic [1:0] bk, input logic [11:0] a,
                       output int waited);
    waited = 0;
    req_valid = 1; req_cmd = c; req_bank = bk; req_addr = a;
    #1;
    while (!req_ready && waited < 40) begin
      @(negedge clk); #1;
      waited++;
      chk(pins() == NOP, "R11 pins NOP while waiting", pins(), NOP);
    end
    @(negedge clk);
    req_valid = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(pins() == NOP, "R1 reset pins", pins(), NOP);
    chk(err == 0, "R1 reset err", err, 0);
    req_cmd = 1; req_bank = 0; #1;
    chk(req_ready == 1, "R1 read to closed bank consumed after reset", req_ready, 1);
  endtask

  task automatic t_act_rd_wr();
    int w;
    do_reset();
    issue(0, 2'd1, 12'h123, w);
    chk(w == 0, "R2 activate accepted at once", w, 0);
    chk(pins() == ACT, "R2 activate pins", pins(), ACT);
    chk(ba == 2'd1 && addr == 12'h123, "R2 activate bank/row", {ba, addr}, {2'd1, 12'h123});
    issue(1, 2'd1, 12'h010, w);
    chk(w == E_RCD - 1, "R5 read waits activate-to-access", w, E_RCD - 1);
    chk(pins() == RD, "R2 read pins", pins(), RD);
    chk(addr == 12'h010, "R2 read column", addr, 12'h010);
    issue(2, 2'd1, 12'h020, w);
    chk(w == 0, "R5 write after limit met", w, 0);
    chk(pins() == WR, "R2 write pins", pins(), WR);
    chk(err == 0, "R10 no error on legal traffic", err, 0);
  endtask

  task automatic t_cross_bank();
    int w;
    do_reset();
    issue(0, 2'd2, 12'h0AA, w);
    issue(0, 2'd3, 12'h0BB, w);
    chk(w == E_RRD - 1, "R7 cross-bank activate spacing", w, E_RRD - 1);
    chk(pins() == ACT && ba == 2'd3, "R7 second activate issued", {pins(), 2'(ba)}, {ACT, 2'd3});
  endtask

  task automatic t_same_bank_rc();
    int w;
    do_reset();
    issue(0, 2'd0, 12'h001, w);
    issue(3, 2'd0, 12'h000, w);
    chk(w == 0 && pins() == PRE, "R8 precharge issued at once", pins(), PRE);
    issue(0, 2'd0, 12'h002, w);
    // activate at edge 0, precharge at edge 1, next activate no earlier than edge E_RC
    chk(w == E_RC - 2, "R6 same-bank activate spacing", w, E_RC - 2);
    chk(pins() == ACT && addr == 12'h002, "R6 reactivate issued", addr, 12'h002);
  endtask

  task automatic t_precharge_rp();
    int w;
    do_reset();
    issue(0, 2'd1, 12'h005, w);
    idle(10);
    issue(3, 2'd1, 12'h000, w);
    issue(0, 2'd1, 12'h006, w);
    chk(w == E_RP - 1, "R8 precharge recovery", w, E_RP - 1);
    issue(3, 2'd1, 12'h000, w);
    idle(5);
    issue(1, 2'd1, 12'h000, w);
    chk(pins() == NOP && err == 1, "R8 precharge closes bank", err, 1);
  endtask

  task automatic t_bad_rd();
    int w;
    do_reset();
    issue(1, 2'd3, 12'h044, w);
    chk(w == 0, "R3 read to closed bank consumed", w, 0);
    chk(pins() == NOP, "R3 read to closed bank not issued", pins(), NOP);
    chk(err == 1, "R3 error raised", err, 1);
    issue(0, 2'd0, 12'h001, w);
    idle(6);
    chk(err == 1, "R10 error stays set", err, 1);
  endtask

  task automatic t_bad_act();
    int w;
    do_reset();
    issue(0, 2'd2, 12'h011, w);
    idle(10);
    issue(0, 2'd2, 12'h022, w);
    chk(w == 0, "R4 activate to open bank consumed", w, 0);
    chk(pins() == NOP, "R4 activate to open bank not issued", pins(), NOP);
    chk(err == 1, "R4 error raised", err, 1);
    issue(1, 2'd2, 12'h003, w);
    chk(pins() == RD && ba == 2'd2, "R4 bank still open after dropped activate", pins(), RD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_cmd = 0; req_bank = 0; req_addr = 0;
    t_reset();
    t_act_rd_wr();
    t_cross_bank();
    t_same_bank_rc();
    t_precharge_rp();
    t_bad_rd();
    t_bad_act();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule